// File: doc/BRIEF.md
# MSI-Ordered Configuration Completion Gate

This block sits in the completion path of a coherency engine's transaction table. It stops a processor's configuration read from returning ahead of an interrupt message that the chip generated internally and that has not yet become globally visible. Each table entry holds one extra tag bit. The tag is set only when the entry is allocated for a configuration access that the processor started. Several pending-interrupt wires come in, one from each internal interrupt source: the PCIe port interrupt logic, a DMA engine, and a hot-plug, power and error block. The block ORs these wires together. While the OR is high, no tagged entry may complete. Untagged traffic keeps flowing.

Entries are allocated by ID, and a fill later marks each one ready with its completion data. Every cycle the block re-evaluates which ready entries may leave. A fixed-priority pick (lowest ID wins) drives one completion onto a valid/ready output stream. An entry is freed when that stream accepts its completion.

Top module: `cfg_cpl_gate`

## Requirements
- R1: After reset every entry is free and `cpl_valid` is low.
- R2: An allocation is tagged only when `alloc_origin` is 0 (processor) and `alloc_kind` is 2 (config read) or 3 (config write). Kinds 0 and 1, and any access with origin 1 (device inbound), are untagged. `cpl_tagged` reports the tag of the presented entry.
- R3: A tagged entry is never presented on the output while any bit of `msi_pending` is high.
- R4: A filled, untagged entry is presented whatever the state of `msi_pending`.
- R5: A filled, tagged entry becomes eligible in the same cycle in which all `msi_pending` bits are low.
- R6: Among eligible entries, the one with the lowest ID is presented.
- R7: An entry is freed in the cycle its completion is accepted (`cpl_valid` and `cpl_ready` both high). An eligible entry that has not been accepted stays presentable.
- R8: Each `msi_pending` bit alone is enough to block tagged entries.
- R9: `cpl_id` carries the presented entry's ID. `cpl_data` carries the data that arrived with that entry's fill.
- R10: An allocation that targets an occupied entry has no effect. A fill that targets a free entry has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate an entry this cycle |
| alloc_id | input | ID_W | Entry to allocate |
| alloc_origin | input | 1 | 0 = processor, 1 = device inbound |
| alloc_kind | input | 2 | 0 mem, 1 io, 2 config read, 3 config write |
| fill_valid | input | 1 | Completion data is ready for an entry |
| fill_id | input | ID_W | Entry being filled |
| fill_data | input | DATA_W | Completion payload |
| msi_pending | input | N_SRC | One pending-interrupt wire per internal source |
| cpl_valid | output | 1 | A completion is presented |
| cpl_ready | input | 1 | Downstream accepts the completion |
| cpl_id | output | ID_W | ID of the presented entry |
| cpl_data | output | DATA_W | Payload of the presented entry |
| cpl_tagged | output | 1 | Presented entry is a processor configuration access |

## Verification
Two functions can fall in the same cycle: a pending wire can drop in the very cycle that a tagged entry waits next to an untagged one, and fixed priority can then hand the output to a lower-ID tagged entry over an untagged one that was already being shown. The bench provokes this by stalling a tagged entry at ID 1 behind pending bit 0 while untagged entries at IDs 3 and 6 are served. It then clears the bit with ready held low and expects ID 1 with its tag in that same cycle. Each pending bit is also raised on its own to show that it blocks alone.

// File: rtl/cfg_cpl_gate_pkg.sv
package cfg_cpl_gate_pkg;

    typedef enum logic {
        ORIGIN_CPU = 1'b0,
        ORIGIN_DEV = 1'b1
    } origin_e;

    typedef enum logic [1:0] {
        KIND_MEM    = 2'd0,
        KIND_IO     = 2'd1,
        KIND_CFG_RD = 2'd2,
        KIND_CFG_WR = 2'd3
    } kind_e;

    typedef struct packed {
        logic busy;
        logic tag;
        logic done;
    } ent_flags_t;

    function automatic logic needs_ordering(input logic origin, input logic [1:0] kind);
        return (origin == ORIGIN_CPU) && (kind == KIND_CFG_RD || kind == KIND_CFG_WR);
    endfunction

endpackage

// File: rtl/cgate_entry.sv
module cgate_entry
    import cfg_cpl_gate_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_hit,
    input  logic              alloc_tag,
    input  logic              fill_hit,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              free_hit,
    output ent_flags_t        flags,
    output logic [DATA_W-1:0] data
);

    ent_flags_t           flags_q;
    logic [DATA_W-1:0]    data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            data_q  <= '0;
        end else if (free_hit) begin
            flags_q <= '0;
        end else if (alloc_hit && !flags_q.busy) begin
            flags_q.busy <= 1'b1;
            flags_q.tag  <= alloc_tag;
            flags_q.done <= 1'b0;
        end else if (fill_hit && flags_q.busy && !flags_q.done) begin
            flags_q.done <= 1'b1;
            data_q       <= fill_data;
        end
    end

    assign flags = flags_q;
    assign data  = data_q;

endmodule

// File: rtl/cgate_prio_arb.sv
module cgate_prio_arb #(
    parameter int N   = 8,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    output logic [N-1:0]   grant,
    output logic [IDW-1:0] grant_idx,
    output logic           grant_any
);

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !grant_any) begin
                grant_any = 1'b1;
                grant[i]  = 1'b1;
                grant_idx = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/cfg_cpl_gate.sv
module cfg_cpl_gate
    import cfg_cpl_gate_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int N_SRC  = 3,
    parameter int ID_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ID_W-1:0]   alloc_id,
    input  logic              alloc_origin,
    input  logic [1:0]        alloc_kind,
    input  logic              fill_valid,
    input  logic [ID_W-1:0]   fill_id,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [N_SRC-1:0]  msi_pending,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [ID_W-1:0]   cpl_id,
    output logic [DATA_W-1:0] cpl_data,
    output logic              cpl_tagged
);

    localparam int LAST = DEPTH - 1;

    ent_flags_t        ent_flags [DEPTH];
    logic [DATA_W-1:0] ent_data  [DEPTH];
    logic [DEPTH-1:0]  ent_done;
    logic [DEPTH-1:0]  ent_tag;
    logic [DEPTH-1:0]  eligible;
    logic [DEPTH-1:0]  grant;
    logic              msi_any;
    logic              alloc_tag;

    assign msi_any   = |msi_pending;
    assign alloc_tag = needs_ordering(alloc_origin, alloc_kind);

    for (genvar g = 0; g <= LAST; g++) begin : g_ent
        logic alloc_hit;
        logic fill_hit;
        logic free_hit;

        assign alloc_hit = alloc_valid && (alloc_id == ID_W'(g));
        assign fill_hit  = fill_valid  && (fill_id  == ID_W'(g));
        assign free_hit  = grant[g] && cpl_ready;

        cgate_entry #(.DATA_W(DATA_W)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .alloc_hit (alloc_hit),
            .alloc_tag (alloc_tag),
            .fill_hit  (fill_hit),
            .fill_data (fill_data),
            .free_hit  (free_hit),
            .flags     (ent_flags[g]),
            .data      (ent_data[g])
        );

        assign ent_done[g] = ent_flags[g].done;
        assign ent_tag[g]  = ent_flags[g].tag;
        assign eligible[g] = ent_flags[g].done && !(ent_flags[g].tag && msi_any);
    end

    cgate_prio_arb #(.N(DEPTH), .IDW(ID_W)) u_arb (
        .req       (eligible),
        .grant     (grant),
        .grant_idx (cpl_id),
        .grant_any (cpl_valid)
    );

    assign cpl_data   = ent_data[cpl_id];
    assign cpl_tagged = ent_tag[cpl_id];

endmodule

// File: rtl/cfg_cpl_gate_chk.sv
module cfg_cpl_gate_chk #(
    parameter int DEPTH = 8,
    parameter int N_SRC = 3,
    parameter int ID_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] msi_pending,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic             cpl_tagged,
    input logic [ID_W-1:0]  cpl_id,
    input logic [DEPTH-1:0] ent_done,
    input logic [DEPTH-1:0] ent_tag,
    input logic [DEPTH-1:0] grant
);

    assert_tag_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && (|msi_pending)) |-> !cpl_tagged);

    assert_untagged_flows_R4: assert property (@(posedge clk) disable iff (rst)
        (|(ent_done & ~ent_tag)) |-> cpl_valid);

    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        ((|ent_done) && !(|msi_pending)) |-> cpl_valid);

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (cpl_valid == (|grant)));

    assert_grant_matches_id_R9: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> grant[cpl_id]);

    assert_freed_R7: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && cpl_ready) |=> !ent_done[$past(cpl_id)]);

endmodule

bind cfg_cpl_gate cfg_cpl_gate_chk #(
    .DEPTH (DEPTH),
    .N_SRC (N_SRC),
    .ID_W  (ID_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .msi_pending (msi_pending),
    .cpl_valid   (cpl_valid),
    .cpl_ready   (cpl_ready),
    .cpl_tagged  (cpl_tagged),
    .cpl_id      (cpl_id),
    .ent_done    (ent_done),
    .ent_tag     (ent_tag),
    .grant       (grant)
);

// File: tb/tb_cfg_cpl_gate.sv
module tb_cfg_cpl_gate;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int N_SRC  = 3;
    localparam int ID_W   = 3;
    localparam int NROWS  = 30;

    typedef struct packed {
        logic       a_v;
        logic [2:0] a_id;
        logic       a_org;
        logic [1:0] a_kind;
        logic       f_v;
        logic [2:0] f_id;
        logic [2:0] pend;
        logic       rdy;
        logic       e_v;
        logic [2:0] e_id;
        logic       e_tag;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        //  a_v a_id org kind f_v f_id pend   rdy e_v e_id e_tag
        '{1'b1, 3'd2, 1'b0, 2'd2, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 0
        '{1'b1, 3'd5, 1'b1, 2'd2, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 1
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd2, 3'b001, 1'b0, 1'b0, 3'd0, 1'b0}, // 2
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd5, 3'b001, 1'b0, 1'b0, 3'd0, 1'b0}, // 3
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b010, 1'b0, 1'b1, 3'd5, 1'b0}, // 4
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b010, 1'b1, 1'b1, 3'd5, 1'b0}, // 5
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b100, 1'b0, 1'b0, 3'd0, 1'b0}, // 6
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b1, 3'd2, 1'b1}, // 7
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b1, 1'b1, 3'd2, 1'b1}, // 8
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 9
        '{1'b1, 3'd6, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 10
        '{1'b1, 3'd1, 1'b0, 2'd3, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 11
        '{1'b1, 3'd3, 1'b1, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 12
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd6, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 13
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd1, 3'b001, 1'b0, 1'b1, 3'd6, 1'b0}, // 14
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd3, 3'b001, 1'b0, 1'b1, 3'd6, 1'b0}, // 15
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b001, 1'b0, 1'b1, 3'd3, 1'b0}, // 16
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b1, 3'd1, 1'b1}, // 17
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b1, 1'b1, 3'd1, 1'b1}, // 18
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b1, 1'b1, 3'd3, 1'b0}, // 19
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b1, 1'b1, 3'd6, 1'b0}, // 20
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 21
        '{1'b1, 3'd4, 1'b0, 2'd2, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 22
        '{1'b1, 3'd4, 1'b1, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 23
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd4, 3'b100, 1'b0, 1'b0, 3'd0, 1'b0}, // 24
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b100, 1'b0, 1'b0, 3'd0, 1'b0}, // 25
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b1, 1'b1, 3'd4, 1'b1}, // 26
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 27
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd7, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}, // 28
        '{1'b0, 3'd0, 1'b0, 2'd0, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 3'd0, 1'b0}  // 29
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_valid = 1'b0;
    logic [ID_W-1:0]   alloc_id = '0;
    logic              alloc_origin = 1'b0;
    logic [1:0]        alloc_kind = '0;
    logic              fill_valid = 1'b0;
    logic [ID_W-1:0]   fill_id = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic [N_SRC-1:0]  msi_pending = '0;
    logic              cpl_ready = 1'b0;
    logic              cpl_valid;
    logic [ID_W-1:0]   cpl_id;
    logic [DATA_W-1:0] cpl_data;
    logic              cpl_tagged;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cfg_cpl_gate #(
        .DEPTH(DEPTH), .DATA_W(DATA_W), .N_SRC(N_SRC), .ID_W(ID_W)
    ) dut (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_id(alloc_id),
        .alloc_origin(alloc_origin), .alloc_kind(alloc_kind),
        .fill_valid(fill_valid), .fill_id(fill_id), .fill_data(fill_data),
        .msi_pending(msi_pending),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
        .cpl_id(cpl_id), .cpl_data(cpl_data), .cpl_tagged(cpl_tagged)
    );

    function automatic logic [DATA_W-1:0] payload(input logic [2:0] id);
        return {8'hD0 + 8'(id), 8'(id) * 8'd17};
    endfunction

    function automatic string req_of(input int row);
        case (row)
            0, 1, 4, 5, 14, 15, 22: return "R4";
            2, 3, 25:               return "R3";
            6:                      return "R8";
            7, 17, 26:              return "R5";
            16, 19, 20:             return "R6";
            8, 9, 18, 21, 27:       return "R7";
            23, 24, 28, 29:         return "R10";
            default:                return "R2";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alloc_valid = 1'b0;
        fill_valid  = 1'b0;
        msi_pending = '0;
        cpl_ready   = 1'b0;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "valid after reset", 32'(cpl_valid), 32'd0);

        for (int r = 0; r < NROWS; r++) begin
            @(negedge clk);
            alloc_valid  = ROWS[r].a_v;
            alloc_id     = ROWS[r].a_id;
            alloc_origin = ROWS[r].a_org;
            alloc_kind   = ROWS[r].a_kind;
            fill_valid   = ROWS[r].f_v;
            fill_id      = ROWS[r].f_id;
            fill_data    = payload(ROWS[r].f_id);
            msi_pending  = ROWS[r].pend;
            cpl_ready    = ROWS[r].rdy;
            #1;
            check(req_of(r), $sformatf("row %0d valid", r), 32'(cpl_valid), 32'(ROWS[r].e_v));
            if (ROWS[r].e_v) begin
                check(req_of(r), $sformatf("row %0d id", r), 32'(cpl_id), 32'(ROWS[r].e_id));
                check("R2", $sformatf("row %0d tag", r), 32'(cpl_tagged), 32'(ROWS[r].e_tag));
                check("R9", $sformatf("row %0d data", r), 32'(cpl_data), 32'(payload(ROWS[r].e_id)));
            end
        end

        // R1: reset in the middle of traffic drops a ready entry
        @(negedge clk);
        idle_inputs();
        alloc_valid = 1'b1; alloc_id = 3'd0; alloc_origin = 1'b1; alloc_kind = 2'd0;
        @(negedge clk);
        alloc_valid = 1'b0;
        fill_valid = 1'b1; fill_id = 3'd0; fill_data = payload(3'd0);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check("R4", "untagged ready before reset", 32'(cpl_valid), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "valid after mid-run reset", 32'(cpl_valid), 32'd0);

        // R8: all pending bits together still block a tagged entry; R2 kind 3
        @(negedge clk);
        alloc_valid = 1'b1; alloc_id = 3'd7; alloc_origin = 1'b0; alloc_kind = 2'd3;
        @(negedge clk);
        alloc_valid = 1'b0;
        fill_valid = 1'b1; fill_id = 3'd7; fill_data = payload(3'd7);
        msi_pending = 3'b111;
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        check("R8", "all pending bits block", 32'(cpl_valid), 32'd0);
        @(negedge clk);
        msi_pending = 3'b000;
        #1;
        check("R5", "release after pending drops", 32'(cpl_valid), 32'd1);
        check("R2", "cfg write from cpu tagged", 32'(cpl_tagged), 32'd1);
        check("R9", "released data", 32'(cpl_data), 32'(payload(3'd7)));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule